// File: doc/BRIEF.md
# Two-Digit Multiplexed Decimal Counter Display

This block keeps a free-running decimal count from 0 to 19 and shows it on two digits of a common-anode seven-segment display. Both digits share one segment bus. A refresh divider switches the bus between the units digit and the tens digit. A slower step divider advances the count with a one-cycle enable, so the whole design runs on a single clock.

The count is held as two BCD digit registers. Each digit feeds the glyph decoder directly, with no division or modulus step. After 19 both digits clear to 00. The tens digit shows a zero for values below ten; it is not blanked.

The segment and anode buses come from one shared output register stage. On every clock edge they update together, so the glyph always belongs to the digit that is lit.

A reset input clears everything. Its assertion is asynchronous and active low, and its release is synchronised inside the block. The step period defaults to 25,000,000 cycles. The refresh period defaults to 25,000 cycles, which gives about 1 kHz per digit at a 50 MHz clock.

Top module: `dual_digit_counter_display`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after its synchronised release, `an_no` is 1110 and `seg_no` is 0000001 (units digit showing 0). After release, counting starts again from 0.
- R2: `an_no` only ever takes the value 1110 (units digit lit) or 1101 (tens digit lit). Bits 3 and 2 always stay high. The value switches every `REFRESH_CYCLES` clock cycles.
- R3: The displayed value runs 0, 1, 2, … 19 and then returns to 0. Each advance moves it by exactly one.
- R4: For displayed values 0 to 9, the tens digit shows the glyph for 0 (0000001); it is not blanked.
- R5: Glyphs are active low, with bit 6 driving segment a down to bit 0 driving segment g. The codes are: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R6: The value advances once every `STEP_CYCLES` clock cycles, driven by a single-cycle enable. It holds between enables.
- R7: The digit decoder drives 1111111 (all segments off) for any digit code from 10 to 15.
- R8: Out of reset, `seg_no` always carries a valid digit glyph. Neither digit is ever dark, and segments and anodes change together on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| seg_no | output | 7 | Active-low segments, bit 6 = a … bit 0 = g |
| an_no | output | 4 | Active-low digit enables; bit 0 = units, bit 1 = tens |

## Verification
The assertions assume that reset is held long enough for the synchroniser to clear every register. They also assume the clock runs continuously, since the dividers are the only timing source. The bench holds reset for several cycles both at start-up and in the middle of a run, and it releases reset on a falling clock edge.

The bench uses short divider periods (40 and 4) so that a full wrap fits in a few hundred cycles. With these periods the step and refresh boundaries fall on the same edges. Because a value change can land on a digit switch, the bench accepts a displayed value only after reading it twice in a row.

// File: rtl/ddisp_pkg.sv
package ddisp_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] glyph_t;
  typedef logic [3:0] anode_t;

  localparam anode_t AN_UNITS   = 4'b1110;
  localparam anode_t AN_TENS    = 4'b1101;
  localparam glyph_t GLYPH_OFF  = 7'b1111111;
  localparam glyph_t GLYPH_ZERO = 7'b0000001;
endpackage

// File: rtl/ddisp_rst_sync.sv
module ddisp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/ddisp_tick_div.sv
module ddisp_tick_div #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = at_last;
endmodule

// File: rtl/ddisp_bcd_count.sv
module ddisp_bcd_count
  import ddisp_pkg::*;
#(
  parameter int unsigned TOP_TENS  = 1,
  parameter int unsigned TOP_UNITS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output bcd_t tens_o,
  output bcd_t units_o
);
  localparam bcd_t LAST_TENS  = bcd_t'(TOP_TENS);
  localparam bcd_t LAST_UNITS = bcd_t'(TOP_UNITS);
  localparam bcd_t NINE       = 4'd9;

  bcd_t tens_q, tens_d, units_q, units_d;
  logic at_top;

  assign at_top = (tens_q == LAST_TENS) && (units_q == LAST_UNITS);

  always_comb begin
    tens_d  = tens_q;
    units_d = units_q;
    if (step_i) begin
      if (at_top) begin
        tens_d  = '0;
        units_d = '0;
      end else if (units_q == NINE) begin
        units_d = '0;
        tens_d  = tens_q + 1'b1;
      end else begin
        units_d = units_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tens_q  <= '0;
      units_q <= '0;
    end else begin
      tens_q  <= tens_d;
      units_q <= units_d;
    end
  end

  assign tens_o  = tens_q;
  assign units_o = units_q;
endmodule

// File: rtl/ddisp_seg_decode.sv
module ddisp_seg_decode
  import ddisp_pkg::*;
(
  input  bcd_t   digit_i,
  output glyph_t seg_no
);
  always_comb begin
    case (digit_i)
      4'd0:    seg_no = 7'b0000001;
      4'd1:    seg_no = 7'b1001111;
      4'd2:    seg_no = 7'b0010010;
      4'd3:    seg_no = 7'b0000110;
      4'd4:    seg_no = 7'b1001100;
      4'd5:    seg_no = 7'b0100100;
      4'd6:    seg_no = 7'b0100000;
      4'd7:    seg_no = 7'b0001111;
      4'd8:    seg_no = 7'b0000000;
      4'd9:    seg_no = 7'b0000100;
      default: seg_no = GLYPH_OFF;
    endcase
  end
endmodule

// File: rtl/dual_digit_counter_display.sv
module dual_digit_counter_display
  import ddisp_pkg::*;
#(
  parameter int unsigned STEP_CYCLES    = 25_000_000,
  parameter int unsigned REFRESH_CYCLES = 25_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [6:0] seg_no,
  output logic [3:0] an_no
);
  logic   rst_sync_n;
  logic   step_tick, refresh_tick;
  bcd_t   tens, units, shown;
  logic   sel_q, sel_d;
  glyph_t seg_d, seg_q;
  anode_t an_d, an_q;

  ddisp_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ddisp_tick_div #(.PERIOD(STEP_CYCLES)) u_step_div (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (step_tick)
  );

  ddisp_tick_div #(.PERIOD(REFRESH_CYCLES)) u_refresh_div (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (refresh_tick)
  );

  ddisp_bcd_count #(.TOP_TENS(1), .TOP_UNITS(9)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .step_i  (step_tick),
    .tens_o  (tens),
    .units_o (units)
  );

  // Digit select: 0 = units, 1 = tens
  always_comb begin
    sel_d = sel_q;
    if (refresh_tick) sel_d = ~sel_q;
  end

  always_comb begin
    shown = sel_q ? tens : units;
    an_d  = sel_q ? AN_TENS : AN_UNITS;
  end

  ddisp_seg_decode u_dec (
    .digit_i (shown),
    .seg_no  (seg_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= 1'b0;
      seg_q <= GLYPH_ZERO;
      an_q  <= AN_UNITS;
    end else begin
      sel_q <= sel_d;
      seg_q <= seg_d;
      an_q  <= an_d;
    end
  end

  assign seg_no = seg_q;
  assign an_no  = an_q;
endmodule

// File: rtl/ddisp_checker.sv
module ddisp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       step_tick,
  input logic [3:0] tens,
  input logic [3:0] units,
  input logic [6:0] seg_o,
  input logic [3:0] an_o
);
  int unsigned val;
  assign val = 10 * int'(tens) + int'(units);

  p_reset_view_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (an_o == 4'b1110 && seg_o == 7'b0000001));

  p_anode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (an_o == 4'b1110 || an_o == 4'b1101));

  p_digit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (units <= 4'd9 && tens <= 4'd1));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (val == (($past(val) == 19) ? 0 : $past(val) + 1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> ($stable(tens) && $stable(units)));

  p_never_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_o != 7'b1111111);
endmodule

bind dual_digit_counter_display ddisp_checker u_chk (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .step_tick (step_tick),
  .tens      (tens),
  .units     (units),
  .seg_o     (seg_no),
  .an_o      (an_no)
);

// File: tb/dual_digit_counter_display_bench.sv
`timescale 1ns/1ps
module dual_digit_counter_display_bench;
  localparam int STEP = 40;
  localparam int REFR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] seg;
  logic [3:0] an;
  logic [3:0] dec_in = 4'd0;
  logic [6:0] dec_out;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_digit_counter_display #(.STEP_CYCLES(STEP), .REFRESH_CYCLES(REFR))
    u_dual_digit_counter_display (.clk_i(clk), .rst_ni(rst_n), .seg_no(seg), .an_no(an));

  ddisp_seg_decode u_dec (.digit_i(dec_in), .seg_no(dec_out));

  function automatic logic [6:0] glyph(int d);
    case (d)
      0: return 7'b0000001; 1: return 7'b1001111; 2: return 7'b0010010;
      3: return 7'b0000110; 4: return 7'b1001100; 5: return 7'b0100100;
      6: return 7'b0100000; 7: return 7'b0001111; 8: return 7'b0000000;
      9: return 7'b0000100; default: return 7'b1111111;
    endcase
  endfunction

  function automatic int unglyph(logic [6:0] g);
    for (int d = 0; d < 10; d++) if (glyph(d) == g) return d;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int bad_an = 0;
  int bad_seg = 0;

  task automatic wait_an(input logic [3:0] code);
    int guard = 0;
    do begin
      @(negedge clk);
      if (rst_n) begin
        if (an != 4'b1110 && an != 4'b1101) bad_an++;
        if (unglyph(seg) < 0) bad_seg++;
      end
      guard++;
    end while (an != code && guard < 100);
  endtask

  task automatic read_pair(output int v, output logic [6:0] tg);
    logic [6:0] ug;
    wait_an(4'b1110); ug = seg;
    wait_an(4'b1101); tg = seg;
    v = (unglyph(tg) < 0 || unglyph(ug) < 0) ? -1 : unglyph(tg) * 10 + unglyph(ug);
  endtask

  task automatic read_confirmed(output int v, output logic [6:0] tg);
    int a, b;
    logic [6:0] g;
    read_pair(a, g);
    for (int i = 0; i < 50; i++) begin
      read_pair(b, tg);
      if (a == b) break;
      a = b;
    end
    v = b;
  endtask

  task automatic test_reset_start();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(an == 4'b1110, "R1 anode in reset", an, 4'b1110);
    check(seg == 7'b0000001, "R1 segments in reset", seg, 7'b0000001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(an == 4'b1110, "R1 anode after release", an, 4'b1110);
  endtask

  task automatic test_sequence();
    int v, prev, conf, steps;
    logic [6:0] tg;
    longint t0;
    read_confirmed(conf, tg);
    check(conf == 0, "R3 first value", conf, 0);
    check(tg == 7'b0000001, "R4 tens glyph at 0", tg, 7'b0000001);
    t0 = cyc;
    prev = conf;
    steps = 0;
    for (int i = 0; i < 1000 && steps < 20; i++) begin
      read_pair(v, tg);
      if (v == prev && v != conf) begin
        check(v == (conf + 1) % 20, "R3 next value", v, (conf + 1) % 20);
        if (v < 10) check(tg == 7'b0000001, "R4 tens shows zero", tg, 7'b0000001);
        conf = v;
        steps++;
      end
      prev = v;
    end
    check(steps == 20, "R3 full wrap reached", steps, 20);
    check((cyc - t0) >= 20 * STEP - 4 * REFR && (cyc - t0) <= 20 * STEP + 4 * REFR,
          "R6 step period", cyc - t0, 20 * STEP);
    check(bad_an == 0, "R2 anode codes legal", bad_an, 0);
    check(bad_seg == 0, "R8 glyph always valid", bad_seg, 0);
  endtask

  task automatic test_refresh();
    logic [3:0] last;
    int n;
    @(negedge clk); last = an;
    for (int g = 0; g < 100 && an == last; g++) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      last = an; n = 0;
      for (int g = 0; g < 100 && an == last; g++) begin @(negedge clk); n++; end
      check(n == REFR, "R2 refresh window", n, REFR);
    end
  endtask

  task automatic test_decoder();
    for (int d = 0; d < 16; d++) begin
      dec_in = 4'(d); #1;
      if (d < 10) check(dec_out == glyph(d), "R5 glyph table", dec_out, glyph(d));
      else        check(dec_out == 7'b1111111, "R7 blank above 9", dec_out, 7'b1111111);
    end
  endtask

  task automatic test_reset_midrun();
    int v;
    logic [6:0] tg;
    repeat (5 * STEP) @(negedge clk);
    rst_n = 1'b0; #1;
    check(an == 4'b1110, "R1 async anode", an, 4'b1110);
    check(seg == 7'b0000001, "R1 async segments", seg, 7'b0000001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_confirmed(v, tg);
    check(v == 0, "R1 restart from 0", v, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset_start();
    test_sequence();
    test_refresh();
    test_decoder();
    test_reset_midrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule